// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Controller

This block is the digital sequencer of an 8-bit successive-approximation converter that sits on a microprocessor bus. The bus uses active-low chip-select, write and read strobes and an active-low interrupt. A write strobe with chip-select resets the sequencer and arms it. When the strobe is released, a conversion starts on the next slot boundary of a free-running phase counter. A single travelling token walks an 8-stage shift register from the most significant bit down. Each bit gets an 8-clock slot. During that slot the trial code is driven to an external DAC, and the comparator answer is taken on the slot's last clock.

When the token leaves the last stage, the decided word is copied into an output latch and the interrupt is raised one clock later. A read with chip-select clears the interrupt and enables the latched word onto the data outputs. A new start during a conversion abandons that conversion without touching the latch. The write strobe can be tied to the interrupt output, with chip-select held low, so that the converter restarts itself after every result. All three strobes are asynchronous and are synchronized inside the block.

Top module: `sar_bus_ctrl`

## Requirements
- R1: While chip-select and write are both low, the sequencer is held idle: trial_o reads 0 and intr_no stays high, even if a result was pending before the strobe.
- R2: After the write strobe rises, a conversion starts. intr_no falls between 66 and 80 clock cycles after that rising edge, a span that includes strobe synchronization and slot alignment.
- R3: Bits are tried from the most significant down. The first trial code is 0x80. Each trial code is held for exactly 8 clocks. A trial bit is kept when cmp_i is 1 (input at or above the trial level) and cleared when cmp_i is 0. The next lower bit is set at the start of the following slot.
- R4: The result equals the code found by the binary search. An input at full scale gives 0xFF and an input at zero gives 0x00.
- R5: intr_no goes low only after a finished word has been loaded into the output latch.
- R6: A read (chip-select and read both low) drives data_oe_o to 1 and data_o to the latched word, and returns intr_no high. Outside a read, data_oe_o is 0 and data_o is 0.
- R7: A start command issued during a conversion abandons that conversion. The latch keeps the earlier result until a later conversion completes.
- R8: With chip-select low and write tied to intr_no, conversions repeat without further stimulus after one initial write pulse, and the latch follows the input.
- R9: After reset, intr_no is 1, data_oe_o is 0 and the latched word is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select, active low, asynchronous |
| wr_ni | input | 1 | Start strobe, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| trial_o | output | 8 | Trial code for the external DAC |
| data_o | output | 8 | Latched result, driven during a read, otherwise 0 |
| data_oe_o | output | 1 | Output driver enable, high during a read |
| intr_no | output | 1 | Result-ready interrupt, active low |

## Verification
The bench models an ideal DAC and comparator, so every conversion should return the input code. It tries the extremes 0x00 and 0xFF, which check that no bit is wrongly kept or dropped at either end. It also tries the patterns 0xA5, 0x3C and 0x01, whose alternating and sparse bits separate a wrong bit order or a wrong keep/clear sense from a correct search. Slot width and the first two trial codes are measured directly. Wide start strobes, a restart in mid-conversion, and a self-restarting loop whose input changes between results show whether the hold, the abort rule and the latch update are kept apart correctly.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned SLOT_LEN    = 8;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned WIDTH     = 3,
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= {WIDTH{RESET_VAL}};
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/start_ctrl.sv
module start_ctrl #(
  parameter int unsigned SLOT_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  output logic go_o
);
  localparam int unsigned PH_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

  logic [PH_W-1:0] phase_q;
  logic            armed_q;

  // free-running phase; conversions only launch on a slot boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (phase_q == PH_W'(SLOT_LEN - 1)) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign go_o = armed_q && !start_req_i && (phase_q == PH_W'(SLOT_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (start_req_i) armed_q <= 1'b1;
    else if (go_o) armed_q <= 1'b0;
  end

  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_i |=> armed_q); // R2
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SLOT_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              go_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic              xfer_o
);
  localparam int unsigned SL_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] token_q, sar_q, decided;
  logic [SL_W-1:0]   slot_q;
  logic              xfer_q, busy, slot_end;

  assign busy     = |token_q;
  assign slot_end = busy && (slot_q == SL_W'(SLOT_LEN - 1));
  assign decided  = cmp_i ? sar_q : (sar_q & ~token_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      token_q <= '0;
      sar_q   <= '0;
      slot_q  <= '0;
      xfer_q  <= 1'b0;
    end else if (hold_i) begin
      token_q <= '0;
      sar_q   <= '0;
      slot_q  <= '0;
      xfer_q  <= 1'b0;
    end else begin
      xfer_q <= 1'b0;
      if (go_i) begin
        token_q <= MSB_ONE;
        sar_q   <= MSB_ONE;
        slot_q  <= '0;
      end else if (busy) begin
        if (slot_end) begin
          slot_q  <= '0;
          token_q <= token_q >> 1;
          sar_q   <= decided | (token_q >> 1);
          xfer_q  <= token_q[0];
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  assign trial_o = sar_q;
  assign xfer_o  = xfer_q;

  AST_TOKEN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(token_q)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (token_q == '0 && sar_q == '0)); // R1
  AST_NEXT_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end && !hold_i && !token_q[0]) |=> $countones(token_q) == 1); // R3
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
  parameter int unsigned DATA_W      = sar_pkg::DATA_W,
  parameter int unsigned SLOT_LEN    = sar_pkg::SLOT_LEN,
  parameter int unsigned SYNC_STAGES = sar_pkg::SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              intr_no
);
  logic [2:0] strobe_s;
  logic       start_req, rd_req, go, xfer;
  logic [DATA_W-1:0] trial, latch_q;
  logic       done_q, intr_q;

  bus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({rd_ni, wr_ni, cs_ni}),
    .sync_o  (strobe_s)
  );

  assign start_req = !strobe_s[0] && !strobe_s[1];
  assign rd_req    = !strobe_s[0] && !strobe_s[2];

  start_ctrl #(.SLOT_LEN(SLOT_LEN)) u_start (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_req_i (start_req),
    .go_o        (go)
  );

  sar_seq #(.DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (start_req),
    .go_i    (go),
    .cmp_i   (cmp_i),
    .trial_o (trial),
    .xfer_o  (xfer)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (xfer) latch_q <= trial;
      done_q <= xfer && !start_req;
    end
  end

  // set wins over read-clear; start hold wins over both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) intr_q <= 1'b0;
    else if (start_req) intr_q <= 1'b0;
    else if (done_q) intr_q <= 1'b1;
    else if (rd_req) intr_q <= 1'b0;
  end

  assign trial_o   = trial;
  assign intr_no   = !intr_q;
  assign data_oe_o = rd_req;
  assign data_o    = rd_req ? latch_q : '0;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> $stable(latch_q)); // R7
  AST_INTR_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intr_q) |-> $past(xfer, 2)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !done_q) |=> !intr_q); // R6
  AST_HOLD_NO_INTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req |=> !intr_q); // R1
endmodule

// File: tb/sar_bus_ctrl_test.sv
module sar_bus_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, wr_drv = 1'b1, rd_ni = 1'b1;
  logic       loop_mode = 1'b0;
  logic [7:0] analog_v = 8'h00;
  logic       wr_ni, cmp_i;
  logic [7:0] trial_o, data_o;
  logic       data_oe_o, intr_no;
  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  assign wr_ni = wr_drv & (loop_mode ? intr_no : 1'b1);
  assign cmp_i = (analog_v >= trial_o);

  sar_bus_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni), .rd_ni(rd_ni),
    .cmp_i(cmp_i), .trial_o(trial_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .intr_no(intr_no)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // start strobe: returns with wr just released at a negedge
  task automatic start_pulse(input int width);
    @(negedge clk_i);
    cs_ni = 1'b0; wr_drv = 1'b0;
    cycles(width);
    wr_drv = 1'b1; cs_ni = 1'b1;
  endtask

  task automatic wait_intr(output int n);
    n = 0;
    while (intr_no && n < 300) begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end
  endtask

  task automatic bus_read(output logic [7:0] d, output logic oe);
    @(negedge clk_i);
    cs_ni = 1'b0; rd_ni = 1'b0;
    cycles(4);
    d = data_o; oe = data_oe_o;
    rd_ni = 1'b1; cs_ni = 1'b1;
    cycles(4);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    check(intr_no == 1'b1, "R9 intr after reset", int'(intr_no), 1);
    check(data_oe_o == 1'b0, "R9 oe after reset", int'(data_oe_o), 0);
    check(trial_o == 8'h00, "R1 trial idle", int'(trial_o), 0);
    bus_read(d, oe);
    check(d == 8'h00, "R9 latch after reset", int'(d), 0);
    check(oe == 1'b1, "R6 oe during read", int'(oe), 1);
  endtask

  task automatic t_convert(input logic [7:0] val);
    int n; logic [7:0] d; logic oe;
    analog_v = val;
    start_pulse(3);
    wait_intr(n);
    check(n >= 66 && n <= 80, "R2 start-to-intr cycles", n, 72);
    check(data_oe_o == 1'b0 && data_o == 8'h00, "R6 idle bus", int'(data_o), 0);
    bus_read(d, oe);
    check(d == val, "R4 result", int'(d), int'(val));
    check(intr_no == 1'b1, "R6 intr cleared by read", int'(intr_no), 1);
    check(data_oe_o == 1'b0, "R6 oe after read", int'(data_oe_o), 0);
  endtask

  task automatic t_slot;
    int n, w; logic [7:0] d; logic oe;
    analog_v = 8'h3C;
    start_pulse(3);
    n = 0;
    while (trial_o == 8'h00 && n < 40) begin @(negedge clk_i); n++; end
    check(trial_o == 8'h80, "R3 first trial", int'(trial_o), 8'h80);
    w = 0;
    while (trial_o == 8'h80 && w < 20) begin @(negedge clk_i); w++; end
    check(w == 8, "R3 slot length", w, 8);
    check(trial_o == 8'h40, "R3 second trial", int'(trial_o), 8'h40);
    wait_intr(n);
    bus_read(d, oe);
    check(d == 8'h3C, "R4 result 0x3C", int'(d), 8'h3C);
  endtask

  task automatic t_hold;
    int n, bad; logic [7:0] d; logic oe;
    analog_v = 8'h6E;
    start_pulse(3);
    wait_intr(n); // leave result unread, intr low
    @(negedge clk_i);
    cs_ni = 1'b0; wr_drv = 1'b0;
    cycles(4);
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (intr_no !== 1'b1 || trial_o !== 8'h00) bad++;
    end
    check(bad == 0, "R1 held idle during wide strobe", bad, 0);
    analog_v = 8'h17;
    wr_drv = 1'b1; cs_ni = 1'b1;
    wait_intr(n);
    check(n >= 66 && n <= 80, "R2 start after wide strobe", n, 72);
    bus_read(d, oe);
    check(d == 8'h17, "R1 result after hold", int'(d), 8'h17);
  endtask

  task automatic t_abort;
    int n; logic [7:0] d; logic oe;
    analog_v = 8'h5A;
    start_pulse(3);
    wait_intr(n);
    bus_read(d, oe);
    check(d == 8'h5A, "R4 result 0x5A", int'(d), 8'h5A);
    analog_v = 8'h21;
    start_pulse(3);
    cycles(30);
    analog_v = 8'h99;
    start_pulse(3);
    cycles(20);
    bus_read(d, oe);
    check(d == 8'h5A, "R7 latch kept after abort", int'(d), 8'h5A);
    wait_intr(n);
    check(n <= 80, "R7 restarted conversion ends", n, 72);
    bus_read(d, oe);
    check(d == 8'h99, "R7 new result", int'(d), 8'h99);
  endtask

  task automatic t_loop;
    int falls, guard; logic prev; logic [7:0] d; logic oe;
    analog_v = 8'h44;
    cs_ni = 1'b0;
    loop_mode = 1'b1;
    @(negedge clk_i);
    wr_drv = 1'b0; cycles(3); wr_drv = 1'b1;
    falls = 0; guard = 0; prev = intr_no;
    while (falls < 2 && guard < 1000) begin
      @(negedge clk_i); guard++;
      if (prev && !intr_no) falls++;
      prev = intr_no;
    end
    check(falls == 2, "R8 repeated conversions", falls, 2);
    analog_v = 8'h77;
    falls = 0; guard = 0;
    while (falls < 2 && guard < 1000) begin
      @(negedge clk_i); guard++;
      if (prev && !intr_no) falls++;
      prev = intr_no;
    end
    check(falls == 2, "R8 loop keeps running", falls, 2);
    loop_mode = 1'b0; cs_ni = 1'b1;
    cycles(100);
    bus_read(d, oe);
    check(d == 8'h77, "R8 latch follows input", int'(d), 8'h77);
  endtask

  initial begin : watchdog
    int cnt = 0;
    while (cnt < 150000) begin @(posedge clk_i); cnt++; end
    errors++;
    $display("FAIL watchdog expired after %0d cycles", cnt);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    rst_ni = 1'b1;
    cycles(3);
    t_reset();
    t_convert(8'h00);
    t_convert(8'hFF);
    t_convert(8'hA5);
    t_convert(8'h01);
    t_slot();
    t_hold();
    t_abort();
    t_loop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule